// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Wrong-Path Squash

This block settles equal and not-equal conditional branches in the decode stage of a five-stage in-order pipeline. Fetch always moves on to the sequential address, so every branch is in effect predicted not taken. While a branch sits in the fetch/decode register, the block compares its two source operands and forms the target address. When the branch is taken, it steers the program counter to the target and, in normal mode, turns the one wrong-path instruction that was fetched behind the branch into a bubble.

The block holds the fetch program counter and the fetch/decode pipeline register. A decoder outside the block reads the instruction in that register and supplies the branch kind, the two operand values and the offset, already sign-extended. A hazard unit can hold the front end with a stall request. When a stall and a redirect fall in the same cycle, the stall wins and the branch is evaluated again on a later cycle. A mode input selects delay-slot behaviour. In that mode the instruction after a branch is always kept and no squash is ever raised.

Top module: `branch_resolve_unit`

## Requirements
- R1: While reset is held low, and right after it is released, pcOut is the reset address 0, idValid is 0, idInstr is 0, and nextPcSel and flush are 0.
- R2: With no taken branch and no stall, pcOut rises by 4 on every clock edge. On the same edge the fetch/decode register captures fetchInstr with idValid set to 1 and idPcPlus4 set to the old pcOut plus 4.
- R3: idBrType uses 2'b01 for branch-if-equal, 2'b10 for branch-if-not-equal and 2'b00 for no branch. A valid branch is taken exactly when its condition holds between rsVal and rtVal.
- R4: branchTarget equals idPcPlus4 plus idOffset shifted left by two bits, and a negative offset moves the target backwards.
- R5: A taken branch with no stall drives nextPcSel to 1 in the same cycle. pcOut equals branchTarget after the next edge.
- R6: In normal mode (delaySlotMode = 0) a taken branch raises flush in the same cycle. After the next edge idInstr is all zeros and idValid is 0.
- R7: In delay-slot mode (delaySlotMode = 1) flush stays 0. The instruction fetched behind a taken branch is captured with idValid = 1, so one more instruction retires than in normal mode.
- R8: While stallReq is 1, pcOut and the fetch/decode register keep their values and nextPcSel and flush are 0, even for a taken branch. The branch redirects once the stall is removed.
- R9: A branch whose condition fails causes no redirect and no flush, and costs no cycle: pcOut keeps rising by 4.
- R10: A bubble (idValid = 0) never redirects, whatever the decoder reports for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| delaySlotMode | input | 1 | 1 keeps the instruction after a branch and never flushes |
| stallReq | input | 1 | Holds the PC and the fetch/decode register for this cycle |
| fetchInstr | input | 32 | Instruction read at pcOut |
| idBrType | input | 2 | Branch kind of the decode instruction: 00 none, 01 equal, 10 not equal |
| rsVal | input | 32 | First compared operand |
| rtVal | input | 32 | Second compared operand |
| idOffset | input | 32 | Sign-extended word offset of the branch |
| pcOut | output | 32 | Current fetch address |
| idInstr | output | 32 | Instruction held in the fetch/decode register |
| idValid | output | 1 | The decode instruction is real, not a bubble |
| idPcPlus4 | output | 32 | Sequential address that follows the decode instruction |
| nextPcSel | output | 1 | 1 when the next PC is branchTarget |
| branchTarget | output | 32 | Computed branch destination |
| flush | output | 1 | Squashes the fetch/decode entry at the next edge |

## Verification
nextPcSel, flush and branchTarget are combinational in the decode cycle. Each check on them samples half a clock period after the edge that brought the branch into the fetch/decode register, or 1 ns after a change of stallReq. pcOut, idInstr and idValid change one edge later, so the check for a redirect, a bubble or a hold looks one negedge further on. The retired count adds up the valid, unstalled decode entries just before each edge, and each scenario compares that total over a fixed window of six edges.

// File: rtl/brn_pkg.sv
package brn_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10
  } brKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;
    logic redirect;
    logic squash;
  } brStrobe_t;
endpackage

// File: rtl/brn_ctrl.sv
module brn_ctrl
  import brn_pkg::*;
(
  input  logic      idValid,
  input  brKind_e   brKind,
  input  logic      opsEqual,
  input  logic      stallReq,
  input  logic      delaySlotMode,
  output brStrobe_t strobe
);
  logic condMet;
  logic taken;

  always_comb begin
    unique case (brKind)
      BR_EQ:   condMet = opsEqual;
      BR_NE:   condMet = !opsEqual;
      default: condMet = 1'b0;
    endcase
  end

  assign taken           = idValid && condMet;
  assign strobe.hold     = stallReq;
  assign strobe.redirect = taken && !stallReq;      // stall has priority
  assign strobe.squash   = taken && !stallReq && !delaySlotMode;
endmodule

// File: rtl/brn_datapath.sv
module brn_datapath
  import brn_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int INSTR_W  = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  brStrobe_t          strobe,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [XLEN-1:0]    rsVal,
  input  logic [XLEN-1:0]    rtVal,
  input  logic [XLEN-1:0]    idOffset,
  output logic               opsEqual,
  output logic [XLEN-1:0]    pcOut,
  output logic [INSTR_W-1:0] idInstr,
  output logic               idValid,
  output logic [XLEN-1:0]    idPcPlus4,
  output logic [XLEN-1:0]    branchTarget
);
  localparam logic [XLEN-1:0]    STEP = XLEN'(4);
  localparam logic [INSTR_W-1:0] NOP  = '0;

  logic [XLEN-1:0] seqPc;

  assign opsEqual     = (rsVal == rtVal);
  assign seqPc        = pcOut + STEP;
  assign branchTarget = idPcPlus4 + {idOffset[XLEN-3:0], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcOut <= RESET_PC;
    end else if (!strobe.hold) begin
      pcOut <= strobe.redirect ? branchTarget : seqPc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idInstr   <= NOP;
      idValid   <= 1'b0;
      idPcPlus4 <= '0;
    end else if (!strobe.hold) begin
      idPcPlus4 <= seqPc;
      if (strobe.squash) begin
        idInstr <= NOP;
        idValid <= 1'b0;
      end else begin
        idInstr <= fetchInstr;
        idValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brn_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               delaySlotMode,
  input  logic               stallReq,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [1:0]         idBrType,
  input  logic [XLEN-1:0]    rsVal,
  input  logic [XLEN-1:0]    rtVal,
  input  logic [XLEN-1:0]    idOffset,
  output logic [XLEN-1:0]    pcOut,
  output logic [INSTR_W-1:0] idInstr,
  output logic               idValid,
  output logic [XLEN-1:0]    idPcPlus4,
  output logic               nextPcSel,
  output logic [XLEN-1:0]    branchTarget,
  output logic               flush
);
  brStrobe_t strobe;
  logic      opsEqual;

  brn_ctrl u_ctrl (
    .idValid       (idValid),
    .brKind        (brKind_e'(idBrType)),
    .opsEqual      (opsEqual),
    .stallReq      (stallReq),
    .delaySlotMode (delaySlotMode),
    .strobe        (strobe)
  );

  brn_datapath #(.XLEN(XLEN), .INSTR_W(INSTR_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .fetchInstr   (fetchInstr),
    .rsVal        (rsVal),
    .rtVal        (rtVal),
    .idOffset     (idOffset),
    .opsEqual     (opsEqual),
    .pcOut        (pcOut),
    .idInstr      (idInstr),
    .idValid      (idValid),
    .idPcPlus4    (idPcPlus4),
    .branchTarget (branchTarget)
  );

  assign nextPcSel = strobe.redirect;
  assign flush     = strobe.squash;
endmodule

// File: rtl/brn_checker.sv
module brn_checker #(
  parameter int XLEN    = 32,
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               delaySlotMode,
  input logic               stallReq,
  input logic [INSTR_W-1:0] fetchInstr,
  input logic [1:0]         idBrType,
  input logic [XLEN-1:0]    rsVal,
  input logic [XLEN-1:0]    rtVal,
  input logic [XLEN-1:0]    idOffset,
  input logic [XLEN-1:0]    pcOut,
  input logic [INSTR_W-1:0] idInstr,
  input logic               idValid,
  input logic [XLEN-1:0]    idPcPlus4,
  input logic               nextPcSel,
  input logic [XLEN-1:0]    branchTarget,
  input logic               flush
);
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stallReq && !nextPcSel) |=> (pcOut == $past(pcOut) + XLEN'(4)));

  a_r3_eq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (idValid && !stallReq && idBrType == 2'b01 && rsVal == rtVal) |-> nextPcSel);

  a_r3_ne_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (idValid && !stallReq && idBrType == 2'b10 && rsVal != rtVal) |-> nextPcSel);

  a_r5_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    nextPcSel |=> (pcOut == $past(branchTarget)));

  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!idValid && idInstr == '0));

  a_r7_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    delaySlotMode |-> !flush);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stallReq |=> (pcOut == $past(pcOut) && idInstr == $past(idInstr)
                  && idValid == $past(idValid)));

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stallReq |-> (!nextPcSel && !flush));

  a_r10_bubble_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !idValid |-> !nextPcSel);

  always_comb begin
    if (!rst_n) a_r1_reset: assert (!nextPcSel && !flush);
  end
endmodule

bind branch_resolve_unit brn_checker #(.XLEN(XLEN), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/tb_branch_resolve_unit.sv
module tb_branch_resolve_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        delaySlotMode;
  logic        stallReq;
  logic [31:0] fetchInstr;
  logic [1:0]  idBrType;
  logic [31:0] rsVal, rtVal, idOffset;
  logic [31:0] pcOut, idInstr, idPcPlus4, branchTarget;
  logic        idValid, nextPcSel, flush;

  int passCount = 0;
  int totalCount = 0;
  int retired;
  bit done = 0;

  // decoder model: up to three branches keyed by address
  logic [31:0] bAddr [3];
  logic [1:0]  bKind [3];
  logic        bEq   [3];
  logic [31:0] bOff  [3];

  always #5 clk = ~clk;

  assign fetchInstr = 32'hC000_0000 | pcOut;

  always_comb begin
    idBrType = 2'b00;
    rsVal    = 32'h11;
    rtVal    = 32'h11;
    idOffset = 32'h0;
    for (int i = 0; i < 3; i++) begin
      if (bKind[i] != 2'b00 && (idPcPlus4 - 32'd4) == bAddr[i]) begin
        idBrType = bKind[i];
        rtVal    = bEq[i] ? 32'h11 : 32'h22;
        idOffset = bOff[i];
      end
    end
  end

  branch_resolve_unit dut (.*);

  function automatic logic [31:0] tok(input logic [31:0] a);
    return 32'hC000_0000 | a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalCount++;
    if (act === exp) passCount++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic tick();
    if (idValid && !stallReq) retired++;
    @(negedge clk);
  endtask

  task automatic doReset(input logic mode);
    for (int i = 0; i < 3; i++) begin
      bAddr[i] = '0; bKind[i] = 2'b00; bEq[i] = 1'b0; bOff[i] = '0;
    end
    stallReq = 1'b0;
    delaySlotMode = mode;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    retired = 0;
  endtask

  task automatic testReset();
    doReset(1'b0);
    chk("R1 pc", pcOut, 32'h0);
    chk("R1 valid", {31'b0, idValid}, 32'h0);
    chk("R1 instr", idInstr, 32'h0);
    chk("R1 sel/flush", {30'b0, nextPcSel, flush}, 32'h0);
  endtask

  task automatic testSequential();
    doReset(1'b0);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R2 pc", pcOut, 32'(4 * k));
      chk("R2 instr", idInstr, tok(32'(4 * (k - 1))));
      chk("R2 pcp4", idPcPlus4, 32'(4 * k));
    end
    chk("R2 valid", {31'b0, idValid}, 32'h1);
  endtask

  task automatic testTakenNormal();
    doReset(1'b0);
    bAddr[0] = 32'd8; bKind[0] = 2'b01; bEq[0] = 1'b1; bOff[0] = 32'd4;
    repeat (3) tick();
    chk("R3 beq taken sel", {31'b0, nextPcSel}, 32'h1);
    chk("R6 flush", {31'b0, flush}, 32'h1);
    chk("R4 target", branchTarget, 32'd28);
    tick();
    chk("R5 pc", pcOut, 32'd28);
    chk("R6 valid", {31'b0, idValid}, 32'h0);
    chk("R6 instr", idInstr, 32'h0);
    tick();
    chk("R5 pc next", pcOut, 32'd32);
    chk("R5 instr", idInstr, tok(32'd28));
    tick();
    chk("R6 retired", 32'(retired), 32'd4);
  endtask

  task automatic testDelaySlot();
    doReset(1'b1);
    bAddr[0] = 32'd8; bKind[0] = 2'b01; bEq[0] = 1'b1; bOff[0] = 32'd4;
    repeat (3) tick();
    chk("R7 sel", {31'b0, nextPcSel}, 32'h1);
    chk("R7 flush", {31'b0, flush}, 32'h0);
    tick();
    chk("R7 pc", pcOut, 32'd28);
    chk("R7 slot instr", idInstr, tok(32'd12));
    chk("R7 slot valid", {31'b0, idValid}, 32'h1);
    repeat (2) tick();
    chk("R7 retired", 32'(retired), 32'd5);
  endtask

  task automatic testNotTaken();
    doReset(1'b0);
    bAddr[0] = 32'd8; bKind[0] = 2'b01; bEq[0] = 1'b0; bOff[0] = 32'd4;
    repeat (3) tick();
    chk("R9 sel", {31'b0, nextPcSel}, 32'h0);
    chk("R9 flush", {31'b0, flush}, 32'h0);
    tick();
    chk("R9 pc", pcOut, 32'd16);
    chk("R9 instr", idInstr, tok(32'd12));
    doReset(1'b0);
    bAddr[0] = 32'd8; bKind[0] = 2'b10; bEq[0] = 1'b1; bOff[0] = 32'd4;
    repeat (3) tick();
    chk("R3 bne equal not taken", {31'b0, nextPcSel}, 32'h0);
  endtask

  task automatic testBackward();
    doReset(1'b0);
    bAddr[0] = 32'd8; bKind[0] = 2'b10; bEq[0] = 1'b0; bOff[0] = 32'hFFFF_FFFD;
    repeat (3) tick();
    chk("R3 bne taken", {31'b0, nextPcSel}, 32'h1);
    chk("R4 neg target", branchTarget, 32'd0);
    tick();
    chk("R5 back pc", pcOut, 32'd0);
  endtask

  task automatic testStall();
    doReset(1'b0);
    bAddr[0] = 32'd8; bKind[0] = 2'b01; bEq[0] = 1'b1; bOff[0] = 32'd4;
    repeat (3) tick();
    stallReq = 1'b1;
    #1;
    chk("R8 sel", {31'b0, nextPcSel}, 32'h0);
    chk("R8 flush", {31'b0, flush}, 32'h0);
    tick();
    chk("R8 pc held", pcOut, 32'd12);
    chk("R8 instr held", idInstr, tok(32'd8));
    stallReq = 1'b0;
    #1;
    chk("R8 retry sel", {31'b0, nextPcSel}, 32'h1);
    tick();
    chk("R8 retry pc", pcOut, 32'd28);
  endtask

  task automatic testBackToBack();
    doReset(1'b0);
    bAddr[0] = 32'd8;  bKind[0] = 2'b01; bEq[0] = 1'b1; bOff[0] = 32'd4;
    bAddr[1] = 32'd12; bKind[1] = 2'b01; bEq[1] = 1'b1; bOff[1] = 32'd100;
    bAddr[2] = 32'd28; bKind[2] = 2'b10; bEq[2] = 1'b0; bOff[2] = 32'd2;
    repeat (4) tick();
    chk("R10 bubble sel", {31'b0, nextPcSel}, 32'h0);
    tick();
    chk("R10 pc", pcOut, 32'd32);
    chk("R5 second sel", {31'b0, nextPcSel}, 32'h1);
    chk("R4 second target", branchTarget, 32'd40);
    tick();
    chk("R5 second pc", pcOut, 32'd40);
    chk("R6 second bubble", {31'b0, idValid}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    stallReq = 1'b0;
    delaySlotMode = 1'b0;
    @(negedge clk);
    testReset();
    testSequential();
    testTakenNormal();
    testDelaySlot();
    testNotTaken();
    testBackward();
    testStall();
    testBackToBack();
    done = 1;
    $display("%0d/%0d checks passed", passCount, totalCount);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      totalCount++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", passCount, totalCount);
      $finish;
    end
  end
endmodule